// File: doc/BRIEF.md
# Set-Associative LRU Tag Lookup Engine

This block decides, for every memory reference it is given, whether the reference hits or misses in a set-associative cache, and keeps each set's replacement order up to date. It stores tags only, with no data. A request carries a byte address and a byte count. The block returns a one-cycle completion pulse with a single miss flag. If the bytes cover more than two lines, it returns an error pulse instead. Every miss allocates, whether the reference is a read or a write.

Each set holds its tags in recency order, with slot 0 as the most recently used. A hit moves the matching tag to slot 0, and the tags that were in front of it move back one slot. A miss pushes every tag back one slot, drops the oldest tag and puts the new tag in slot 0. A reference whose bytes cross into the next line is looked up in two sets, one after the other, and gives one combined result.

The block is controlled by a four-state machine:
- `ST_IDLE` accepts a request and classifies it. It moves to `ST_LOOK_FIRST` for a one-line or two-line reference, and to `ST_FAULT` for a reference that spans too many lines.
- `ST_LOOK_FIRST` checks and updates the first set. It returns to `ST_IDLE` for a one-line reference, or moves to `ST_LOOK_SECOND` for a two-line reference.
- `ST_LOOK_SECOND` checks and updates the second set, then returns to `ST_IDLE`.
- `ST_FAULT` raises the error pulse and returns to `ST_IDLE`.

Top module: `lru_tag_lookup`

## Requirements
- R1: With the default parameters (1024-byte cache, 16-byte lines, 4 ways, 32-bit address), there are 16 sets. The set index is address bits [7:4], and the tag is address bits [31:8]. The number of sets is (cache bytes / line bytes) / ways.
- R2: After reset, every tag slot holds zero and there are no valid bits, so a reference whose tag is zero hits. Straight after reset, `req_ready` is 1 and `rsp_done`, `rsp_miss` and `rsp_err` are 0.
- R3: A hit reports `rsp_miss`=0. A hit in slot 0 leaves the set unchanged. A hit in slot i>0 moves that tag to slot 0, and slots 0..i-1 each move back one slot.
- R4: A miss reports `rsp_miss`=1. Every slot moves back one slot, the tag in the last slot is discarded, and the new tag is written to slot 0.
- R5: A one-line reference is one where the set of address+size-1 equals the set of the address. Its `rsp_done` is high in the cycle after the first clock edge that follows the accepting edge.
- R6: A two-line reference is one where the last byte's set equals (first set + 1) mod sets. The engine looks up and updates the first set using the tag of the first address. It then looks up and updates the second set using the tag of the last byte address. `rsp_done` comes one cycle later than for a one-line reference, and `rsp_miss` is 1 if either line missed.
- R7: A reference whose last byte's set is neither the first set nor the next set raises `rsp_err` for one cycle, at the same time a one-line result would appear. It gives no `rsp_done` and changes no tags.
- R8: A request is accepted on a clock edge when `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the accepting edge until the result is presented.
- R9: With one way (direct-mapped), a new tag always replaces the single resident tag of its set. Only the same tag hits again.
- R10: `rsp_done` and `rsp_err` are single-cycle pulses, and `rsp_miss` is high only together with `rsp_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all tags to zero |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Byte address of the first byte referenced |
| req_size | input | SIZE_W | Number of bytes referenced |
| req_ready | output | 1 | Engine idle and able to accept a request |
| rsp_done | output | 1 | One-cycle pulse carrying the result of a reference |
| rsp_miss | output | 1 | The reference missed (valid only with `rsp_done`) |
| rsp_err | output | 1 | One-cycle pulse: the reference spans more than two lines |

## Verification
Take edge E0 as the edge that accepts a request. For a one-line reference or an out-of-range reference, the result is visible after edge E1. For a two-line reference it is visible after edge E2, and `rsp_done` stays low after E1. The bench drives requests and samples at falling edges. At the falling edge just after E0, it checks that `req_ready` is 0. It then counts one or two more falling edges, depending on the class it has predicted for the reference, and checks the pulse in exactly that half-cycle. At the next falling edge it checks that the pulse has gone. A bench-side model of the recency order predicts every miss flag.

// File: rtl/lru_lookup_pkg.sv
package lru_lookup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOK_FIRST,
        ST_LOOK_SECOND,
        ST_FAULT
    } lookup_state_e;

    typedef enum logic [1:0] {
        SPAN_ONE,
        SPAN_TWO,
        SPAN_BAD
    } span_e;

endpackage

// File: rtl/lru_addr_split.sv
module lru_addr_split
    import lru_lookup_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 8,
    parameter int OFF_W  = 4,
    parameter int IDX_W  = 4,
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  last_idx,
    output logic [TAG_W-1:0]  first_tag,
    output logic [TAG_W-1:0]  last_tag,
    output span_e             span
);

    logic [ADDR_W-1:0] last_addr;
    logic [IDX_W-1:0]  next_idx;

    always_comb begin
        last_addr = addr + ADDR_W'(size) - ADDR_W'(1);
        first_idx = IDX_W'(addr >> OFF_W);
        last_idx  = IDX_W'(last_addr >> OFF_W);
        first_tag = TAG_W'(addr >> (OFF_W + IDX_W));
        last_tag  = TAG_W'(last_addr >> (OFF_W + IDX_W));
        next_idx  = first_idx + IDX_W'(1);
        if (last_idx == first_idx) begin
            span = SPAN_ONE;
        end else if (last_idx == next_idx) begin
            span = SPAN_TWO;
        end else begin
            span = SPAN_BAD;
        end
    end

endmodule

// File: rtl/lru_way_match.sv
module lru_way_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [POS_W-1:0]           pos
);

    // Lowest slot wins when duplicates exist (e.g. zeros after reset).
    always_comb begin
        hit = 1'b0;
        pos = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (row[w] == tag) begin
                hit = 1'b1;
                pos = POS_W'(w);
            end
        end
    end

endmodule

// File: rtl/lru_tag_store.sv
module lru_tag_store #(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(SETS),
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [IDX_W-1:0]           idx,
    output logic [WAYS-1:0][TAG_W-1:0] row,
    input  logic                       wr_en,
    input  logic                       wr_hit,
    input  logic [POS_W-1:0]           wr_pos,
    input  logic [TAG_W-1:0]           wr_tag
);

    logic [WAYS-1:0][TAG_W-1:0] rows_q [SETS];
    logic [WAYS-1:0][TAG_W-1:0] row_nxt;

    assign row = rows_q[idx];

    // Slot 0 always receives the referenced tag; slot k takes its
    // front neighbour when the whole set shifts (miss) or when k is at
    // or in front of the hit slot.
    assign row_nxt[0] = wr_tag;

    for (genvar k = 1; k < WAYS; k++) begin : g_shift
        assign row_nxt[k] = (!wr_hit || (POS_W'(k) <= wr_pos)) ? row[k-1] : row[k];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                rows_q[s] <= '0;
            end
        end else if (wr_en) begin
            rows_q[idx] <= row_nxt;
        end
    end

endmodule

// File: rtl/lru_tag_lookup.sv
module lru_tag_lookup
    import lru_lookup_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int SIZE_W      = 8,
    parameter int CACHE_BYTES = 1024,
    parameter int LINE_BYTES  = 16,
    parameter int WAYS        = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_miss,
    output logic              rsp_err
);

    localparam int LINES = CACHE_BYTES / LINE_BYTES;
    localparam int SETS  = LINES / WAYS;
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int POS_W = (WAYS > 1) ? $clog2(WAYS) : 1;

    lookup_state_e state_q, state_d;

    span_e             span_c;
    logic [IDX_W-1:0]  idx_first_c, idx_last_c;
    logic [TAG_W-1:0]  tag_first_c, tag_last_c;

    logic [IDX_W-1:0]  idx_a_q, idx_b_q, look_idx;
    logic [TAG_W-1:0]  tag_a_q, tag_b_q, look_tag;
    logic              two_q, miss_acc_q;

    logic [WAYS-1:0][TAG_W-1:0] cur_row;
    logic              hit;
    logic [POS_W-1:0]  hit_pos;
    logic              upd_en;

    lru_addr_split #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_split (
        .addr      (req_addr),
        .size      (req_size),
        .first_idx (idx_first_c),
        .last_idx  (idx_last_c),
        .first_tag (tag_first_c),
        .last_tag  (tag_last_c),
        .span      (span_c)
    );

    assign look_idx = (state_q == ST_LOOK_SECOND) ? idx_b_q : idx_a_q;
    assign look_tag = (state_q == ST_LOOK_SECOND) ? tag_b_q : tag_a_q;
    assign upd_en   = (state_q == ST_LOOK_FIRST) || (state_q == ST_LOOK_SECOND);

    lru_tag_store #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx    (look_idx),
        .row    (cur_row),
        .wr_en  (upd_en),
        .wr_hit (hit),
        .wr_pos (hit_pos),
        .wr_tag (look_tag)
    );

    lru_way_match #(
        .WAYS  (WAYS),
        .TAG_W (TAG_W)
    ) u_match (
        .row (cur_row),
        .tag (look_tag),
        .hit (hit),
        .pos (hit_pos)
    );

    assign req_ready = (state_q == ST_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = (span_c == SPAN_BAD) ? ST_FAULT : ST_LOOK_FIRST;
                end
            end
            ST_LOOK_FIRST:  state_d = two_q ? ST_LOOK_SECOND : ST_IDLE;
            ST_LOOK_SECOND: state_d = ST_IDLE;
            ST_FAULT:       state_d = ST_IDLE;
        endcase
    end

    // Outputs and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done   <= 1'b0;
            rsp_miss   <= 1'b0;
            rsp_err    <= 1'b0;
            miss_acc_q <= 1'b0;
            two_q      <= 1'b0;
            idx_a_q    <= '0;
            idx_b_q    <= '0;
            tag_a_q    <= '0;
            tag_b_q    <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_miss <= 1'b0;
            rsp_err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_a_q    <= idx_first_c;
                        idx_b_q    <= idx_last_c;
                        tag_a_q    <= tag_first_c;
                        tag_b_q    <= tag_last_c;
                        two_q      <= (span_c == SPAN_TWO);
                        miss_acc_q <= 1'b0;
                    end
                end
                ST_LOOK_FIRST: begin
                    if (two_q) begin
                        miss_acc_q <= !hit;
                    end else begin
                        rsp_done <= 1'b1;
                        rsp_miss <= !hit;
                    end
                end
                ST_LOOK_SECOND: begin
                    rsp_done <= 1'b1;
                    rsp_miss <= miss_acc_q || !hit;
                end
                ST_FAULT: begin
                    rsp_err <= 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/lru_tag_lookup_chk.sv
module lru_tag_lookup_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_done,
    input logic rsp_miss,
    input logic rsp_err
);

    AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);                                    // R10
    AST_ERR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);                                      // R10
    AST_MISS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_done);                                     // R10
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_done);                                     // R7
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                   // R8
    AST_RESULT_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done || rsp_err) |-> $past(!req_ready));               // R5

endmodule

bind lru_tag_lookup lru_tag_lookup_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_miss  (rsp_miss),
    .rsp_err   (rsp_err)
);

// File: tb/lru_tag_lookup_bench.sv
`timescale 1ns/1ps
module lru_tag_lookup_bench;

    localparam int NSETS = 16;
    localparam int NWAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [7:0]  req_size = '0;
    logic        req_ready, rsp_done, rsp_miss, rsp_err;

    logic        dm_valid = 1'b0;
    logic [31:0] dm_addr = '0;
    logic [7:0]  dm_size = 8'd1;
    logic        dm_ready, dm_done, dm_miss, dm_err;

    int checks = 0;
    int errors = 0;

    logic [23:0] mdl [NSETS][NWAYS];

    always #2.5 clk = ~clk;

    lru_tag_lookup u_lru_tag_lookup (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_addr (req_addr),
        .req_size (req_size), .req_ready (req_ready), .rsp_done (rsp_done),
        .rsp_miss (rsp_miss), .rsp_err (rsp_err)
    );

    lru_tag_lookup #(.WAYS(1)) u_dm (
        .clk (clk), .rst_n (rst_n), .req_valid (dm_valid), .req_addr (dm_addr),
        .req_size (dm_size), .req_ready (dm_ready), .rsp_done (dm_done),
        .rsp_miss (dm_miss), .rsp_err (dm_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model of one set update; returns the miss flag.
    task automatic touch(input int s, input logic [23:0] t, output bit miss);
        int pos = -1;
        for (int w = 0; w < NWAYS; w++) begin
            if (pos < 0 && mdl[s][w] == t) pos = w;
        end
        miss = (pos < 0);
        if (pos < 0) pos = NWAYS - 1;
        for (int w = pos; w > 0; w--) mdl[s][w] = mdl[s][w-1];
        mdl[s][0] = t;
    endtask

    task automatic do_ref(input logic [31:0] a, input logic [7:0] sz, input string req);
        logic [31:0] last = a + 32'(sz) - 32'd1;
        int s1 = int'((a >> 4) & 32'hF);
        int s2 = int'((last >> 4) & 32'hF);
        bit m1, m2, two, bad;
        two = (s2 == ((s1 + 1) % NSETS)) && (s1 != s2);
        bad = (s1 != s2) && !two;
        m1 = 1'b0; m2 = 1'b0;
        if (!bad) touch(s1, a[31:8], m1);
        if (two)  touch(s2, last[31:8], m2);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_done == 1'b0 && rsp_err == 1'b0, "R10 idle, no pulse", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy after accept", int'(req_ready), 0);
        @(negedge clk);
        if (bad) begin
            chk(rsp_err == 1'b1, {req, " R7 error pulse"}, int'(rsp_err), 1);
            chk(rsp_done == 1'b0, {req, " R7 no done"}, int'(rsp_done), 0);
        end else if (!two) begin
            chk(rsp_done == 1'b1, {req, " R5 done one-line"}, int'(rsp_done), 1);
            chk(rsp_miss == m1, {req, " miss one-line"}, int'(rsp_miss), int'(m1));
        end else begin
            chk(rsp_done == 1'b0 && req_ready == 1'b0, {req, " R6 still busy"}, int'(rsp_done), 0);
            @(negedge clk);
            chk(rsp_done == 1'b1, {req, " R6 done two-line"}, int'(rsp_done), 1);
            chk(rsp_miss == (m1 | m2), {req, " R6 combined miss"}, int'(rsp_miss), int'(m1 | m2));
        end
    endtask

    task automatic dm_ref(input logic [31:0] a, input bit exp_miss, input string req);
        @(negedge clk);
        dm_valid = 1'b1; dm_addr = a;
        @(negedge clk);
        dm_valid = 1'b0;
        @(negedge clk);
        chk(dm_done == 1'b1 && dm_miss == exp_miss, req, int'(dm_miss), int'(exp_miss));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSETS; s++)
            for (int w = 0; w < NWAYS; w++) mdl[s][w] = '0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(req_ready == 1'b1, "R2 ready after reset", int'(req_ready), 1);
        chk(rsp_done == 1'b0 && rsp_miss == 1'b0 && rsp_err == 1'b0, "R2 quiet after reset", int'(rsp_done), 0);

        // R2 zero tag hits; R1 set 1 (addr bits [7:4]), tag 0
        do_ref(32'h0000_0010, 8'd4, "R2 zero-tag hit R1");
        // R4 fill set 2 with tags 1..4 then push a fifth: tag 1 evicted
        do_ref(32'h0000_0120, 8'd1, "R4 fill");
        do_ref(32'h0000_0220, 8'd1, "R4 fill");
        do_ref(32'h0000_0320, 8'd1, "R4 fill");
        do_ref(32'h0000_0420, 8'd1, "R4 fill");
        do_ref(32'h0000_0520, 8'd1, "R4 new tag");
        do_ref(32'h0000_0120, 8'd1, "R4 evicted tag misses");
        // R3 set 3: hit in last slot moves tag to front, survives next miss
        do_ref(32'h0000_0130, 8'd1, "R3 fill");
        do_ref(32'h0000_0230, 8'd1, "R3 fill");
        do_ref(32'h0000_0330, 8'd1, "R3 fill");
        do_ref(32'h0000_0430, 8'd1, "R3 fill");
        do_ref(32'h0000_0130, 8'd1, "R3 hit last slot");
        do_ref(32'h0000_0130, 8'd1, "R3 hit slot 0");
        do_ref(32'h0000_0630, 8'd1, "R3 miss after promote");
        do_ref(32'h0000_0130, 8'd1, "R3 promoted tag kept");
        do_ref(32'h0000_0230, 8'd1, "R3 oldest evicted");
        // R6 two-line references
        do_ref(32'h0000_010E, 8'd4, "R6 both miss");
        do_ref(32'h0000_010E, 8'd4, "R6 both hit");
        do_ref(32'h0000_0700, 8'd1, "R6 prime first line");
        do_ref(32'h0000_070F, 8'd2, "R6 one line misses");
        do_ref(32'h0000_00FF, 8'd2, "R6 wrap set 15 to 0");
        // R7 out of range span, then confirm table untouched
        do_ref(32'h0000_0105, 8'd40, "R7 three lines");
        do_ref(32'h0000_010E, 8'd4, "R7 table unchanged");

        for (int n = 0; n < 400; n++) begin
            int r = int'($urandom_range(99));
            logic [7:0]  sz;
            logic [31:0] a;
            a = (32'($urandom_range(5)) << 8) | (32'($urandom_range(15)) << 4)
                | 32'($urandom_range(15));
            if (r < 80)      sz = 8'($urandom_range(8, 1));
            else if (r < 95) sz = 8'($urandom_range(16, 9));
            else             sz = 8'($urandom_range(40, 17));
            do_ref(a, sz, "R1 random");
        end

        // R9 direct-mapped: 64 sets, tag = addr[31:10]
        dm_ref(32'h0000_0000, 1'b0, "R9 zero tag hits");
        dm_ref(32'h0000_0400, 1'b1, "R9 new tag misses");
        dm_ref(32'h0000_0400, 1'b0, "R9 same tag hits");
        dm_ref(32'h0000_0000, 1'b1, "R9 replaced tag misses");
        dm_ref(32'h0000_0400, 1'b1, "R9 alternate misses");

        @(negedge clk);
        chk(rsp_done == 1'b0 && rsp_err == 1'b0, "R10 pulses end", int'(rsp_done), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule